// File: doc/BRIEF.md
# Local Interrupt Timer

This block is the countdown timer of a per-processor interrupt controller. Software loads an initial count and the timer counts scaled ticks, where one tick is the system clock divided by a selectable power of two. A control entry chooses one-shot or periodic operation, can mask the timer, and holds the 8-bit vector that is delivered when the timer expires.

All timing is measured from the moment the initial count is written. That write is the reference point, and every expiry follows from the number of scaled ticks elapsed since then. In periodic mode the timer expires each time (initial count + 1) ticks have passed. In one-shot mode it expires once, after (initial count + 1) ticks. A zero initial count never produces an expiry. Each expiry emits a single-cycle request together with its vector. Priority handling and delivery of the request belong to the surrounding controller.

Top module: `lvt_timer`

## Requirements
- R1: After reset the control entry reads 0x00010000 (masked, one-shot, vector 0), and the divide, initial-count and current-count registers read 0. No request is raised.
- R2: The register addresses are: 0 for the control entry, 1 for divide, 2 for the initial count and 3 for the current count, which is read-only. In the control entry the vector is bits 7:0, the mask is bit 16 and periodic mode is bit 17. The divide register keeps only bits 3, 1 and 0. All other bits read back as zero.
- R3: The divide code is {bit3, bit1, bit0}. Codes 0 to 6 select a shift of code+1. Code 7 selects a shift of 0. One scaled tick lasts 2^shift clock cycles, counted from the initial-count write.
- R4: In one-shot mode with initial count C ≥ 1, the request is high in exactly one cycle. That cycle comes n = (C+1)·2^shift cycles after the write edge, where n = 0 is the cycle right after that edge. With C = 0 the request never fires.
- R5: In periodic mode with C ≥ 1, the request is high exactly in the cycles n = m·(C+1)·2^shift for m ≥ 1. With C = 0 it never fires.
- R6: While the mask bit is set, no request is raised. The current count keeps advancing as if unmasked.
- R7: With e = n >> shift, the current count reads C − (e mod (C+1)) in periodic mode. In one-shot mode it reads C − e while e < C, and 0 from then on.
- R8: The request is a one-cycle pulse. Its vector is the control-entry vector held in the cycle before the pulse.
- R9: Rewriting the initial count restarts the reference point. Expiries that were scheduled from the earlier write do not occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected register (combinational) |
| irq_o | output | 1 | Single-cycle expiry request |
| irq_vec_o | output | 8 | Vector carried by the request |

## Verification
The assertions check the following on every cycle: a masked timer stays silent, a disarmed timer never fires, each request lasts one cycle, the vector matches the control entry from the prior cycle, the current count never exceeds the initial count, and reserved control bits read zero. Some properties can only be shown by the bench's scenarios. These are the exact expiry cycle for every divide code, the spacing of periodic expiries, the one-shot count reaching zero and staying there, and the restart of the reference point on a rewrite. The bench sweeps all eight divide codes, both modes and small initial counts, and compares each cycle against arithmetic from the requirements.

// File: rtl/lvt_timer_pkg.sv
package lvt_timer_pkg;
  localparam int REG_AW   = 2;
  localparam int VEC_W    = 8;
  localparam int MASK_BIT = 16;
  localparam int PER_BIT  = 17;
  localparam int SHIFT_W  = 3;
  localparam int PRE_W    = 7;

  localparam logic [REG_AW-1:0] SEL_LVT  = 2'd0;
  localparam logic [REG_AW-1:0] SEL_DIV  = 2'd1;
  localparam logic [REG_AW-1:0] SEL_INIT = 2'd2;
  localparam logic [REG_AW-1:0] SEL_CUR  = 2'd3;

  function automatic logic [SHIFT_W-1:0] div_shift(input logic [2:0] code);
    return (code == 3'b111) ? '0 : SHIFT_W'(code + 3'd1);
  endfunction
endpackage

// File: rtl/lvt_timer_regs.sv
module lvt_timer_regs
  import lvt_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_AW-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W-1:0]   cur_cnt,
  output logic [DATA_W-1:0]   rdata,
  output logic [VEC_W-1:0]    lvt_vec,
  output logic                lvt_mask,
  output logic                lvt_per,
  output logic [SHIFT_W-1:0]  shift,
  output logic [DATA_W-1:0]   init_val,
  output logic                load
);
  logic [VEC_W-1:0]  vec_q, vec_d;
  logic              mask_q, mask_d, per_q, per_d;
  logic [2:0]        code_q, code_d;
  logic [DATA_W-1:0] init_q, init_d;
  logic              lvt_we, div_we;

  assign lvt_we = wr_en && (addr == SEL_LVT);
  assign div_we = wr_en && (addr == SEL_DIV);
  assign load   = wr_en && (addr == SEL_INIT);

  always_comb begin
    vec_d  = vec_q;
    mask_d = mask_q;
    per_d  = per_q;
    code_d = code_q;
    init_d = init_q;
    if (lvt_we) begin
      vec_d  = wdata[VEC_W-1:0];
      mask_d = wdata[MASK_BIT];
      per_d  = wdata[PER_BIT];
    end
    if (div_we) code_d = {wdata[3], wdata[1:0]};
    if (load)   init_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      mask_q <= 1'b1;
      per_q  <= 1'b0;
      code_q <= '0;
      init_q <= '0;
    end else begin
      vec_q  <= vec_d;
      mask_q <= mask_d;
      per_q  <= per_d;
      code_q <= code_d;
      init_q <= init_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      SEL_LVT: begin
        rdata[VEC_W-1:0] = vec_q;
        rdata[MASK_BIT]  = mask_q;
        rdata[PER_BIT]   = per_q;
      end
      SEL_DIV: begin
        rdata[3]   = code_q[2];
        rdata[1:0] = code_q[1:0];
      end
      SEL_INIT: rdata = init_q;
      default:  rdata = cur_cnt;
    endcase
  end

  assign lvt_vec  = vec_q;
  assign lvt_mask = mask_q;
  assign lvt_per  = per_q;
  assign shift    = div_shift(code_q);
  assign init_val = init_q;
endmodule

// File: rtl/lvt_timer_prescale.sv
module lvt_timer_prescale
  import lvt_timer_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  logic [PRE_W-1:0] pre_q, pre_d, sel_mask;

  assign sel_mask = ~({PRE_W{1'b1}} << shift);
  assign tick     = ((pre_q & sel_mask) == sel_mask);

  always_comb begin
    pre_d = load ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/lvt_timer_core.sv
module lvt_timer_core
  import lvt_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic [DATA_W-1:0] init_val,
  input  logic              per,
  input  logic              mask,
  input  logic [VEC_W-1:0]  vec,
  output logic [DATA_W-1:0] cur_cnt,
  output logic              armed,
  output logic              irq,
  output logic [VEC_W-1:0]  irq_vec
);
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              armed_q, armed_d, irq_q, irq_d, fire;
  logic [VEC_W-1:0]  ivec_q, ivec_d;

  assign fire = tick && (cnt_q == '0) && armed_q && !load;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (load) begin
      cnt_d   = load_val;
      armed_d = |load_val;
    end else begin
      if (tick) begin
        if (cnt_q == '0) cnt_d = per ? init_val : '0;
        else             cnt_d = cnt_q - 1'b1;
      end
      if (fire && !per) armed_d = 1'b0;
    end
    irq_d  = fire && !mask;
    ivec_d = fire ? vec : ivec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
      ivec_q  <= '0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      irq_q   <= irq_d;
      ivec_q  <= ivec_d;
    end
  end

  assign cur_cnt = cnt_q;
  assign armed   = armed_q;
  assign irq     = irq_q;
  assign irq_vec = ivec_q;
endmodule

// File: rtl/lvt_timer.sv
module lvt_timer
  import lvt_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o,
  output logic [7:0]        irq_vec_o
);
  logic [1:0]         rsync_q;
  logic               rst_int_n;
  logic [VEC_W-1:0]   lvt_vec;
  logic               lvt_mask, lvt_per, load, tick, armed;
  logic [SHIFT_W-1:0] shift;
  logic [DATA_W-1:0]  init_val, cur_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  lvt_timer_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .cur_cnt(cur_cnt), .rdata(rdata),
    .lvt_vec(lvt_vec), .lvt_mask(lvt_mask), .lvt_per(lvt_per),
    .shift(shift), .init_val(init_val), .load(load)
  );

  lvt_timer_prescale u_pre (
    .clk(clk), .rst_n(rst_int_n), .load(load), .shift(shift), .tick(tick)
  );

  lvt_timer_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .load(load),
    .load_val(wdata), .init_val(init_val), .per(lvt_per), .mask(lvt_mask),
    .vec(lvt_vec), .cur_cnt(cur_cnt), .armed(armed),
    .irq(irq_o), .irq_vec(irq_vec_o)
  );
endmodule

// File: rtl/lvt_timer_chk.sv
module lvt_timer_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] rdata,
  input logic              irq_o,
  input logic [7:0]        irq_vec_o,
  input logic [7:0]        lvt_vec,
  input logic              lvt_mask,
  input logic              lvt_per,
  input logic              armed,
  input logic [DATA_W-1:0] init_val,
  input logic [DATA_W-1:0] cur_cnt
);
  AST_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    lvt_mask |=> !irq_o); // R6
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o); // R8
  AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> irq_vec_o == $past(lvt_vec)); // R8
  AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !irq_o); // R4
  AST_CUR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cur_cnt <= init_val); // R7
  AST_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> cur_cnt == ($past(lvt_per) ? init_val : '0)); // R5
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd0) |-> (rdata[DATA_W-1:18] == '0 && rdata[15:8] == '0)); // R2
endmodule

bind lvt_timer lvt_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .addr(addr), .rdata(rdata),
  .irq_o(irq_o), .irq_vec_o(irq_vec_o), .lvt_vec(lvt_vec),
  .lvt_mask(lvt_mask), .lvt_per(lvt_per), .armed(armed),
  .init_val(init_val), .cur_cnt(cur_cnt)
);

// File: tb/tb_lvt_timer.sv
module tb_lvt_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o;
  logic [7:0]  irq_vec_o;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  lvt_timer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .irq_vec_o(irq_vec_o));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd3;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; #1 d = rdata;
  endtask

  function automatic logic [31:0] lvt_word(input logic per, input logic msk, input logic [7:0] v);
    return {14'd0, per, msk, 8'd0, v};
  endfunction

  // run n = 0..len-1 after an initial-count write; expected values from R4, R5, R7
  task automatic run(input logic per, input int c, input int s, input int len,
                     input logic [7:0] v, input logic masked, input string tag);
    for (int n = 0; n < len; n++) begin
      int e, p, ecur;
      logic eirq;
      e = n >> s;
      p = (c + 1) << s;
      if (per) ecur = c - (e % (c + 1));
      else     ecur = (e >= c) ? 0 : c - e;
      if (c == 0 || masked || n == 0) eirq = 1'b0;
      else if (per) eirq = (n % p) == 0;
      else          eirq = (n == p);
      addr = 2'd3;
      #1;
      chk({tag, " R7 current count"}, rdata, ecur);
      chk({tag, " irq R4/R5"}, {31'd0, irq_o}, {31'd0, eirq});
      if (eirq) chk({tag, " R8 vector"}, {24'd0, irq_vec_o}, {24'd0, v});
      @(negedge clk);
    end
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(2'd0, d); chk("R1 lvt reset", d, 32'h0001_0000);
    rd(2'd1, d); chk("R1 div reset", d, 0);
    rd(2'd2, d); chk("R1 init reset", d, 0);
    rd(2'd3, d); chk("R1 cur reset", d, 0);
    chk("R1 irq reset", {31'd0, irq_o}, 0);

    // R2 readback with reserved bits
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, d); chk("R2 lvt reserved", d, 32'h0003_00FF);
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, d); chk("R2 div reserved", d, 32'h0000_000B);
    wr(2'd0, lvt_word(1'b0, 1'b1, 8'h00));

    // R3 R4 R5 R7 sweep over mode, divide code, initial count
    for (int mode = 0; mode < 2; mode++)
      for (int code = 0; code < 8; code++)
        for (int c = 0; c < 5; c++) begin
          int s;
          logic [7:0] v;
          s = (code == 7) ? 0 : code + 1;
          v = 8'(code * 16 + c * 2 + mode + 32);
          wr(2'd0, lvt_word(mode[0], 1'b0, v));
          wr(2'd1, {28'd0, code[2], 1'b0, code[1:0]});
          wr(2'd2, c);
          run(mode[0], c, s, (2 * ((c + 1) << s)) + 3, v, 1'b0, "R3 sweep");
        end

    // R6 masked periodic: silent, count keeps running
    wr(2'd0, lvt_word(1'b1, 1'b1, 8'h5A));
    wr(2'd1, 32'h0000_000B);
    wr(2'd2, 2);
    run(1'b1, 2, 0, 20, 8'h5A, 1'b1, "R6 masked");

    // R9 rewrite restarts reference
    wr(2'd0, lvt_word(1'b0, 1'b0, 8'h33));
    wr(2'd2, 3);
    @(negedge clk);
    wr(2'd2, 3);
    run(1'b0, 3, 0, 12, 8'h33, 1'b0, "R9 rewrite");

    // R8 vector follows control entry at each expiry
    wr(2'd0, lvt_word(1'b1, 1'b0, 8'hA1));
    wr(2'd2, 3);
    run(1'b1, 3, 0, 5, 8'hA1, 1'b0, "R8 first");
    wr(2'd0, lvt_word(1'b1, 1'b0, 8'hB2));
    begin
      logic seen;
      seen = 1'b0;
      for (int k = 0; k < 10 && !seen; k++) begin
        #1;
        if (irq_o) begin
          seen = 1'b1;
          chk("R8 changed vector", {24'd0, irq_vec_o}, 32'hB2);
        end
        @(negedge clk);
      end
      chk("R8 second expiry seen", {31'd0, seen}, 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule